// File: doc/BRIEF.md
# Goldschmidt Significand Divider

This block divides one normalized binary significand by another using multiplicative convergence. Both operands are unsigned values in [1,2), given as SIG_W-bit integers whose top bit is the hidden one. A small reciprocal table, filled at elaboration by a constant function and indexed by the leading fraction bits of the divisor, provides a first estimate. Both operands are multiplied by that estimate. After that, a fixed number of steps each multiply the running numerator and the running denominator by the factor two minus the denominator, within the same clock. The denominator is driven toward one, and the numerator approaches the quotient.

All arithmetic is fixed point, with two integer bits and SIG_W-1+GUARD fraction bits. Every product is truncated back to that width. The quotient falls in (0.5,2). It is returned with one integer bit, the fraction bits and the guard bits, together with a flag that tells the caller whether a one-bit left shift is needed to normalize it. Sign, exponent, special operands and final rounding belong to the enclosing unit.

Top module: `gsDivider`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, done is 0 and quot is 0. A reset taken during a division cancels it, and no done follows.
- R2: A division is accepted on a rising clock edge at which start is 1 and no division is in progress. dividend and divisor are sampled at that edge and must have their top bit set.
- R3: done is 1 for exactly one cycle. That cycle begins at the ITERS-th rising edge after the accepting edge.
- R4: When done is 1, quot read as an unsigned integer Q (value Q/2^FRAC, FRAC = SIG_W-1+GUARD) satisfies |Q - floor(dividend*2^FRAC/divisor)| <= 2^GUARD, where dividend and divisor are the sampled integers.
- R5: needShift is 1 exactly when bit FRAC of quot (its integer bit) is 0.
- R6: When done is 1, quot is greater than 2^(FRAC-1). The internal numerator and denominator never reach the value 2 while a division is running.
- R7: A start that arrives while a division is in progress is ignored. The running division keeps its timing and its result, and no extra done is produced.
- R8: From done until the next accepted start, quot holds its value, whatever the operand inputs do.
- R9: A start given in the cycle in which done is 1 is accepted, so divisions can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division |
| dividend | input | SIG_W | Numerator significand, top bit set |
| divisor | input | SIG_W | Denominator significand, top bit set |
| quot | output | SIG_W+GUARD | Quotient: integer bit at FRAC, then fraction and guard bits |
| needShift | output | 1 | Quotient is below one; the caller shifts left by one |
| done | output | 1 | One-cycle pulse marking a valid quot |

## Verification
The bound checker watches several properties on every cycle. It checks that done is a single-cycle pulse arriving exactly ITERS edges after an accepted start, that a start arriving mid-division never moves that point, and that quot stays frozen while the block is idle. It also checks that neither running operand overflows the two integer bits, and that at completion the denominator has converged to just below one while the quotient lies above one half. Whether each quotient is actually within one significand unit of the exact ratio depends on the operand values, so only the bench's sweep over every pair of 8-bit significands shows it. The bench scenarios also cover the cancellation of a division by reset, the ignored mid-division start and the back-to-back hand-off.

// File: rtl/gsDivPkg.sv
package gsDivPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands and apply the seed
    logic step;   // one convergence iteration
  } gsStrobe_t;
endpackage

// File: rtl/gsSeedTable.sv
module gsSeedTable #(
  parameter int SEED_BITS = 4,
  parameter int FRAC      = 27,
  parameter int W         = FRAC + 2
) (
  input  logic [SEED_BITS-1:0] idx,
  output logic [W-1:0]         seed
);
  localparam int ENTRIES = 1 << SEED_BITS;

  // reciprocal of the midpoint of interval idx, in FRAC fraction bits
  function automatic logic [63:0] recipMid(input int i);
    logic [63:0] numer;
    logic [63:0] denom;
    numer = 64'(1) << (SEED_BITS + 1 + FRAC);
    denom = (64'(1) << (SEED_BITS + 1)) + 64'(2 * i + 1);
    return numer / denom;
  endfunction

  logic [W-1:0] seedTab [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gSeed
    assign seedTab[i] = W'(recipMid(i));
  end

  assign seed = seedTab[idx];
endmodule

// File: rtl/gsDivDatapath.sv
module gsDivDatapath
  import gsDivPkg::*;
#(
  parameter int SIG_W     = 24,
  parameter int GUARD     = 4,
  parameter int SEED_BITS = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  gsStrobe_t                           strobe,
  input  logic [SIG_W-1:0]                    dividend,
  input  logic [SIG_W-1:0]                    divisor,
  output logic [SIG_W-1+GUARD+2-1:0]          num,
  output logic [SIG_W-1+GUARD+2-1:0]          den
);
  localparam int FRAC = SIG_W - 1 + GUARD;
  localparam int W    = FRAC + 2;
  localparam logic [W-1:0] TWO = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] aFix, bFix, seed, factor;

  assign aFix = {1'b0, dividend, {GUARD{1'b0}}};
  assign bFix = {1'b0, divisor,  {GUARD{1'b0}}};

  gsSeedTable #(.SEED_BITS(SEED_BITS), .FRAC(FRAC), .W(W)) uSeed (
    .idx  (divisor[SIG_W-2 -: SEED_BITS]),
    .seed (seed)
  );

  // two minus the running denominator
  assign factor = TWO - den;

  function automatic logic [W-1:0] mulTrunc(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    return W'(p >> FRAC);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      num <= '0;
      den <= '0;
    end else if (strobe.load) begin
      num <= mulTrunc(aFix, seed);
      den <= mulTrunc(bFix, seed);
    end else if (strobe.step) begin
      num <= mulTrunc(num, factor);
      den <= mulTrunc(den, factor);
    end
  end
endmodule

// File: rtl/gsDivCtrl.sv
module gsDivCtrl
  import gsDivPkg::*;
#(
  parameter int ITERS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output gsStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  logic [CW-1:0] cnt;

  always_comb begin
    strobe.load = start && !busy;
    strobe.step = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gsDivider.sv
module gsDivider
  import gsDivPkg::*;
#(
  parameter int SIG_W     = 24,
  parameter int GUARD     = 4,
  parameter int SEED_BITS = 4,
  parameter int ITERS     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [SIG_W-1:0]       dividend,
  input  logic [SIG_W-1:0]       divisor,
  output logic [SIG_W+GUARD-1:0] quot,
  output logic                   needShift,
  output logic                   done
);
  localparam int FRAC = SIG_W - 1 + GUARD;
  localparam int W    = FRAC + 2;

  gsStrobe_t    strobe;
  logic         busy;
  logic [W-1:0] numVal, denVal;

  gsDivCtrl #(.ITERS(ITERS)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  gsDivDatapath #(.SIG_W(SIG_W), .GUARD(GUARD), .SEED_BITS(SEED_BITS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dividend (dividend),
    .divisor  (divisor),
    .num      (numVal),
    .den      (denVal)
  );

  assign quot      = numVal[FRAC:0];
  assign needShift = !numVal[FRAC];  // R5
endmodule

// File: rtl/gsDivChecker.sv
module gsDivChecker #(
  parameter int SIG_W     = 24,
  parameter int GUARD     = 4,
  parameter int ITERS     = 3
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          start,
  input logic                          busy,
  input logic                          done,
  input logic [SIG_W+GUARD-1:0]        quot,
  input logic [SIG_W-1+GUARD+2-1:0]    num,
  input logic [SIG_W-1+GUARD+2-1:0]    den
);
  localparam int FRAC = SIG_W - 1 + GUARD;
  localparam int W    = FRAC + 2;
  localparam logic [W-1:0]    ONE   = W'(1) << FRAC;
  localparam logic [W-1:0]    NEAR1 = ONE - W'(4);
  localparam logic [FRAC:0]   HALF  = (FRAC+1)'(1) << (FRAC - 1);
  localparam logic [7:0]      LAT   = 8'(ITERS + 1);

  // edges elapsed since the last accepted start, saturating
  logic [7:0] sinceQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            sinceQ <= '0;
    else if (start && !busy)              sinceQ <= 8'd1;
    else if (sinceQ != 0 && sinceQ != '1) sinceQ <= sinceQ + 8'd1;
  end

  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R3
  AST_LATENCY:      assert property (@(posedge clk) disable iff (!rstN) done |-> (sinceQ == LAT)); // R7
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN) done |-> $past(busy)); // R3
  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rstN) (busy || done) |-> (!num[W-1] && !den[W-1])); // R6
  AST_QUOT_RANGE:   assert property (@(posedge clk) disable iff (!rstN) done |-> (quot > HALF)); // R6
  AST_DEN_NEAR_ONE: assert property (@(posedge clk) disable iff (!rstN) done |-> (den <= ONE && den >= NEAR1)); // R4
  AST_QUOT_HELD:    assert property (@(posedge clk) disable iff (!rstN) (!busy && !start) |=> $stable(quot)); // R8
endmodule

bind gsDivider gsDivChecker #(.SIG_W(SIG_W), .GUARD(GUARD), .ITERS(ITERS)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .quot  (quot),
  .num   (numVal),
  .den   (denVal)
);

// File: tb/tb_gsDivider.sv
module tb_gsDivider;
  localparam int SIG_W = 8, GUARD = 4, SEED_BITS = 3, ITERS = 2;
  localparam int FRAC = SIG_W - 1 + GUARD;
  localparam longint TOL = longint'(1) << GUARD;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rstN, start, needShift, done;
  logic [SIG_W-1:0] dividend, divisor;
  logic [SIG_W+GUARD-1:0] quot;

  gsDivider #(.SIG_W(SIG_W), .GUARD(GUARD), .SEED_BITS(SEED_BITS), .ITERS(ITERS)) dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .quot(quot), .needShift(needShift), .done(done)
  );

  int nChk = 0, nBad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic launch(input int a, input int b);
    @(negedge clk);
    start = 1'b1; dividend = SIG_W'(a); divisor = SIG_W'(b);
    @(negedge clk);
    start = 1'b0;
  endtask

  // called one negedge after the accepting edge; returns negedges counted from the launch
  task automatic waitDone(output int cyc);
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic checkQuot(input int a, input int b);
    longint exact, diff;
    exact = (longint'(a) << FRAC) / longint'(b);
    diff  = longint'(quot) - exact;
    check(diff <= TOL && diff >= -TOL, "R4", "quotient accuracy", longint'(quot), exact);
    check(needShift == !quot[FRAC], "R5", "shift flag", longint'(needShift), longint'(!quot[FRAC]));
    check(longint'(quot) > (longint'(1) << (FRAC - 1)), "R6", "quotient above half",
          longint'(quot), (longint'(1) << (FRAC - 1)) + 1);
  endtask

  task automatic doDiv(input int a, input int b, output longint q);
    int cyc;
    launch(a, b);
    waitDone(cyc);
    check(cyc == ITERS + 1, "R3", "done latency", cyc, ITERS + 1);
    checkQuot(a, b);
    q = longint'(quot);
    @(negedge clk);
    check(done == 1'b0, "R3", "done width", longint'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    longint q, refA, refB;
    int cyc;
    bit sawDone;
    rstN = 1'b0; start = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    check(quot == '0, "R1", "quot in reset", longint'(quot), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && quot == '0, "R1", "state after release", longint'(quot), 0);

    // R2 R4: exhaustive sweep of every normalized operand pair
    for (int a = 1 << (SIG_W - 1); a < (1 << SIG_W); a++)
      for (int b = 1 << (SIG_W - 1); b < (1 << SIG_W); b++)
        doDiv(a, b, q);

    // R7: start during a division is ignored
    doDiv(200, 131, refA);
    launch(200, 131);
    start = 1'b1; dividend = 8'd129; divisor = 8'd255;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    check(cyc == ITERS + 1, "R7", "latency with ignored start", cyc, ITERS + 1);
    check(longint'(quot) == refA, "R7", "result with ignored start", longint'(quot), refA);
    sawDone = 0;
    for (int i = 0; i < ITERS + 3; i++) begin
      @(negedge clk);
      if (done) sawDone = 1;
    end
    check(!sawDone, "R7", "no extra done", longint'(sawDone), 0);

    // R8: result held while idle and operands wander
    for (int i = 0; i < 6; i++) begin
      dividend = SIG_W'(128 + 17 * i); divisor = SIG_W'(255 - 9 * i);
      @(negedge clk);
      check(longint'(quot) == refA, "R8", "quot held", longint'(quot), refA);
    end

    // R9: back-to-back with start during the done cycle
    doDiv(150, 250, refB);
    doDiv(250, 150, refA);
    launch(250, 150);
    waitDone(cyc);
    check(longint'(quot) == refA, "R9", "first result", longint'(quot), refA);
    start = 1'b1; dividend = 8'd150; divisor = 8'd250;
    @(negedge clk);
    start = 1'b0;
    waitDone(cyc);
    check(cyc == ITERS + 1, "R9", "second latency", cyc, ITERS + 1);
    check(longint'(quot) == refB, "R9", "second result", longint'(quot), refB);

    // R1: reset cancels a running division
    launch(180, 140);
    rstN = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && quot == '0, "R1", "quot after mid-run reset", longint'(quot), 0);
    rstN = 1'b1;
    sawDone = 0;
    for (int i = 0; i < ITERS + 3; i++) begin
      @(negedge clk);
      if (done) sawDone = 1;
    end
    check(!sawDone, "R1", "no done after cancel", longint'(sawDone), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule